// File: doc/BRIEF.md
# DRAM Controller Register Stub

This block is a word-addressed 32-bit register slave that takes the place of a DRAM controller's control and status registers while boot firmware is brought up. It has no memory timing, no PHY and no calibration hardware. Firmware that starts memory initialization, data training or impedance calibration sees each operation complete at once. A start bit clears itself on the same write that sets it, and a write to the calibration control register raises a done flag in a separate status register.

Three registers are decoded: a clock/command control register, a ZQ calibration control register and a ZQ status register. Each has a fixed reset value. Other word offsets below the out-of-range boundary read as zero and ignore writes. Offsets at or above the boundary also read as zero and ignore writes, and they raise a one-cycle error flag. Read data is registered and comes out one cycle after the read strobe, together with a valid flag.

Top module: `memctl_reg_stub`

## Requirements
- R1: After synchronous active-low reset, the control register (offset 0x000) reads 0x80020000, the ZQ control register (offset 0x0A8) reads 0x07B00000, the ZQ status register (offset 0x0B0) reads 0x80000000, and `rsp_valid` and `oob_err` are low.
- R2: A write to the control register stores bit 31 (initialization start) as 0, whatever value was written to it.
- R3: A write to the control register stores bit 30 (training start) as 0 and stores all other bits exactly as written.
- R4: A write to the ZQ control register stores the written word and sets bit 31 (calibration done) of the ZQ status register, leaving the other status bits unchanged.
- R5: The ZQ status register can be written directly. The written word is stored as given, and the ZQ control register does not change.
- R6: Aligned offsets below 0x2E4 that are not one of the three registers read as zero and raise no error. Writes to them change no register.
- R7: Aligned offsets from 0x2E4 to the top of the window read as zero, and writes to them change no register. Each such access drives `oob_err` high for exactly the one cycle after the access, so back-to-back accesses give back-to-back pulses.
- R8: `rsp_valid` is high exactly in the cycle after a read strobe, and `rsp_data` carries the read word then. In every other cycle `rsp_valid` is low and `rsp_data` is zero.
- R9: Only whole-word accesses are valid. An address whose two low bits are not 00 reads as zero, changes no register (including the calibration done side effect) and raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_addr | input | ADDR_W (12) | Byte address of the access within the register window |
| req_wdata | input | 32 | Write data |
| req_wr | input | 1 | Write strobe, one access per cycle |
| req_rd | input | 1 | Read strobe, one access per cycle |
| rsp_data | output | 32 | Registered read data, zero when not valid |
| rsp_valid | output | 1 | High in the cycle after a read strobe |
| oob_err | output | 1 | One-cycle pulse after an out-of-range access |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle, because the bus performs at most one access per cycle. The checker states this as a property of the inputs. They also assume the address stays inside the 2^ADDR_W-byte window, which holds by construction because of the port width. The stimulus issues every access through a single driver task that raises exactly one strobe per cycle and drops both strobes in idle cycles. Misaligned and out-of-range addresses are chosen on purpose to reach the decode corners without breaking the one-access rule.

// File: rtl/memctl_stub_pkg.sv
// Package: memctl_stub_pkg
// Shared constants and types for the DRAM controller register stub.
// Assumes a 32-bit data path and byte addresses with word alignment.
package memctl_stub_pkg;

    localparam int unsigned DATA_W = 32;

    // Register offsets (bytes) inside the register window
    localparam int unsigned OFS_CTRL     = 32'h000;
    localparam int unsigned OFS_ZQ_CTL   = 32'h0A8;
    localparam int unsigned OFS_ZQ_STAT  = 32'h0B0;
    localparam int unsigned OFS_OOB_BASE = 32'h2E4;

    // Bit positions with side effects
    localparam int unsigned CTRL_INIT_BIT  = 31;
    localparam int unsigned CTRL_TRAIN_BIT = 30;
    localparam int unsigned ZQ_DONE_BIT    = 31;

    // Reset values
    localparam logic [DATA_W-1:0] CTRL_RST    = 32'h8002_0000;
    localparam logic [DATA_W-1:0] ZQ_CTL_RST  = 32'h07B0_0000;
    localparam logic [DATA_W-1:0] ZQ_STAT_RST = 32'h8000_0000;

    // Bits of the control register that clear themselves on write
    localparam logic [DATA_W-1:0] CTRL_SELF_CLR =
        (DATA_W'(1) << CTRL_INIT_BIT) | (DATA_W'(1) << CTRL_TRAIN_BIT);

    // Result of address decode
    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_CTRL    = 3'd1,
        SEL_ZQ_CTL  = 3'd2,
        SEL_ZQ_STAT = 3'd3,
        SEL_OOB     = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/memctl_addr_decode.sv
// Module: memctl_addr_decode
// Maps a byte address to a register select. Misaligned addresses map to
// SEL_NONE. Aligned addresses at or above the out-of-range base map to
// SEL_OOB. Assumes ADDR_W is wide enough to hold the out-of-range base.
module memctl_addr_decode
    import memctl_stub_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_ZQ_CTL  = ADDR_W'(OFS_ZQ_CTL);
    localparam logic [ADDR_W-1:0] A_ZQ_STAT = ADDR_W'(OFS_ZQ_STAT);
    localparam logic [ADDR_W-1:0] A_OOB     = ADDR_W'(OFS_OOB_BASE);

    logic aligned;

    // Whole-word accesses only: the two low address bits must be zero
    always_comb aligned = (addr[1:0] == 2'b00);

    // Select the target register for an aligned access
    always_comb begin
        sel = SEL_NONE;
        if (aligned) begin
            if (addr >= A_OOB)            sel = SEL_OOB;
            else if (addr == A_CTRL)      sel = SEL_CTRL;
            else if (addr == A_ZQ_CTL)    sel = SEL_ZQ_CTL;
            else if (addr == A_ZQ_STAT)   sel = SEL_ZQ_STAT;
        end
    end

endmodule

// File: rtl/memctl_cmd_reg.sv
// Module: memctl_cmd_reg
// A register whose bits in SELF_CLR are always stored as zero, so a
// command written there reads back as already finished. Assumes the
// write enable is a single-cycle strobe.
module memctl_cmd_reg #(
    parameter int unsigned       W        = 32,
    parameter logic [W-1:0]      RST_VAL  = '0,
    parameter logic [W-1:0]      SELF_CLR = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Store the written word with the command bits already finished
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= RST_VAL;
        else if (wr_en)  q <= wdata & ~SELF_CLR;
    end

endmodule

// File: rtl/memctl_zq_block.sv
// Module: memctl_zq_block
// ZQ calibration control and status pair. A write to the control word
// sets the done bit in status. Status can also be written directly.
// Assumes the two write enables are never high together.
module memctl_zq_block
    import memctl_stub_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_wr,
    input  logic         stat_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctl_q,
    output logic [W-1:0] stat_q
);

    localparam logic [W-1:0] DONE_MASK = W'(1) << ZQ_DONE_BIT;

    // Control word: plain storage, nothing clears itself
    memctl_cmd_reg #(
        .W        (W),
        .RST_VAL  (W'(ZQ_CTL_RST)),
        .SELF_CLR ('0)
    ) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ctl_wr),
        .wdata (wdata),
        .q     (ctl_q)
    );

    // Status word: direct write, or done bit set on calibration start
    always_ff @(posedge clk) begin
        if (!rst_n)        stat_q <= W'(ZQ_STAT_RST);
        else if (stat_wr)  stat_q <= wdata;
        else if (ctl_wr)   stat_q <= stat_q | DONE_MASK;
    end

endmodule

// File: rtl/memctl_reg_stub.sv
// Module: memctl_reg_stub
// Top of the DRAM controller register stub. Decodes one bus access per
// cycle, updates the registers, returns registered read data one cycle
// later and pulses oob_err after out-of-range accesses.
// Assumes req_wr and req_rd are never high together.
module memctl_reg_stub
    import memctl_stub_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                req_wr,
    input  logic                req_rd,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                rsp_valid,
    output logic                oob_err
);

    reg_sel_e          sel;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] zq_ctl_q;
    logic [DATA_W-1:0] zq_stat_q;
    logic [DATA_W-1:0] rd_mux;
    logic              wr_ctrl, wr_zq_ctl, wr_zq_stat;

    memctl_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    // Per-register write strobes
    always_comb begin
        wr_ctrl    = req_wr && (sel == SEL_CTRL);
        wr_zq_ctl  = req_wr && (sel == SEL_ZQ_CTL);
        wr_zq_stat = req_wr && (sel == SEL_ZQ_STAT);
    end

    memctl_cmd_reg #(
        .W        (DATA_W),
        .RST_VAL  (CTRL_RST),
        .SELF_CLR (CTRL_SELF_CLR)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_ctrl),
        .wdata (req_wdata),
        .q     (ctrl_q)
    );

    memctl_zq_block #(.W(DATA_W)) u_zq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (wr_zq_ctl),
        .stat_wr (wr_zq_stat),
        .wdata   (req_wdata),
        .ctl_q   (zq_ctl_q),
        .stat_q  (zq_stat_q)
    );

    // Read multiplexer: unimplemented and out-of-range offsets give zero
    always_comb begin
        unique case (sel)
            SEL_CTRL:    rd_mux = ctrl_q;
            SEL_ZQ_CTL:  rd_mux = zq_ctl_q;
            SEL_ZQ_STAT: rd_mux = zq_stat_q;
            default:     rd_mux = '0;
        endcase
    end

    // Registered read response, zero outside a valid cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data  <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= req_rd;
            rsp_data  <= req_rd ? rd_mux : '0;
        end
    end

    // One-cycle error pulse for each out-of-range access
    always_ff @(posedge clk) begin
        if (!rst_n) oob_err <= 1'b0;
        else        oob_err <= (req_wr || req_rd) && (sel == SEL_OOB);
    end

endmodule

// File: rtl/memctl_reg_stub_chk.sv
// Module: memctl_reg_stub_chk
// Checker for memctl_reg_stub, attached with bind. It watches the bus
// ports and the three stored registers.
module memctl_reg_stub_chk
    import memctl_stub_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [DATA_W-1:0]   req_wdata,
    input logic                req_wr,
    input logic                req_rd,
    input logic [DATA_W-1:0]   rsp_data,
    input logic                rsp_valid,
    input logic                oob_err,
    input logic [DATA_W-1:0]   ctrl_q,
    input logic [DATA_W-1:0]   zq_ctl_q,
    input logic [DATA_W-1:0]   zq_stat_q
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_ZQC  = ADDR_W'(OFS_ZQ_CTL);
    localparam logic [ADDR_W-1:0] A_ZQS  = ADDR_W'(OFS_ZQ_STAT);
    localparam logic [ADDR_W-1:0] A_OOB  = ADDR_W'(OFS_OOB_BASE);

    logic acc_oob;
    logic wr_noreg;

    // Classify the current access independently of the decoder
    always_comb begin
        acc_oob  = (req_wr || req_rd) && (req_addr[1:0] == 2'b00) && (req_addr >= A_OOB);
        wr_noreg = req_wr && !(req_addr == A_CTRL || req_addr == A_ZQC || req_addr == A_ZQS);
    end

    // Input rule: one access per cycle
    assert_one_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_wr && req_rd));

    assert_rsp_after_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_rd |=> rsp_valid);

    assert_rsp_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_rd |=> (!rsp_valid && rsp_data == '0));

    assert_init_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_addr == A_CTRL) |=> !ctrl_q[CTRL_INIT_BIT]);

    assert_train_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_addr == A_CTRL) |=>
            (!ctrl_q[CTRL_TRAIN_BIT] &&
             ctrl_q[CTRL_TRAIN_BIT-1:0] == $past(req_wdata[CTRL_TRAIN_BIT-1:0])));

    assert_zq_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_addr == A_ZQC) |=>
            (zq_stat_q[ZQ_DONE_BIT] && zq_ctl_q == $past(req_wdata)));

    assert_zq_stat_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_addr == A_ZQS) |=>
            (zq_stat_q == $past(req_wdata) && $stable(zq_ctl_q)));

    assert_noreg_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_noreg |=> ($stable(ctrl_q) && $stable(zq_ctl_q) && $stable(zq_stat_q)));

    assert_oob_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_oob |=> oob_err);

    assert_oob_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_oob |=> !oob_err);

endmodule

bind memctl_reg_stub memctl_reg_stub_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_wr    (req_wr),
    .req_rd    (req_rd),
    .rsp_data  (rsp_data),
    .rsp_valid (rsp_valid),
    .oob_err   (oob_err),
    .ctrl_q    (ctrl_q),
    .zq_ctl_q  (zq_ctl_q),
    .zq_stat_q (zq_stat_q)
);

// File: tb/tb_memctl_reg_stub.sv
// Bench: tb_memctl_reg_stub
// Scoreboard bench. The driver task applies one bus cycle and queues the
// expected response. The monitor pops each item one clock later and
// compares it with the outputs.
module tb_memctl_reg_stub;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              req_wr = 1'b0;
    logic              req_rd = 1'b0;
    logic [31:0]       rsp_data;
    logic              rsp_valid;
    logic              oob_err;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [31:0] data;
        logic        valid;
        logic        err;
        string       req;
    } exp_t;

    exp_t sb[$];

    memctl_reg_stub #(.ADDR_W(ADDR_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_wr    (req_wr),
        .req_rd    (req_rd),
        .rsp_data  (rsp_data),
        .rsp_valid (rsp_valid),
        .oob_err   (oob_err)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Driver: one bus cycle, with the expected response queued
    task automatic cyc(input bit w, input bit r, input logic [ADDR_W-1:0] a,
                       input logic [31:0] d, input logic [31:0] exp_data,
                       input bit exp_err, input string req);
        exp_t e;
        @(negedge clk);
        req_wr = w; req_rd = r; req_addr = a; req_wdata = d;
        e.data = r ? exp_data : 32'h0;
        e.valid = r;
        e.err = exp_err;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                      input bit eerr, input string req);
        cyc(1'b1, 1'b0, a, d, 32'h0, eerr, req);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                      input bit eerr, input string req);
        cyc(1'b0, 1'b1, a, 32'h0, exp, eerr, req);
    endtask

    task automatic idle(input string req);
        cyc(1'b0, 1'b0, '0, 32'h0, 32'h0, 1'b0, req);
    endtask

    // Monitor: compare outputs one clock after each driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "rsp_valid", 32'(rsp_valid), 32'(e.valid));
                check(e.req, "rsp_data", rsp_data, e.data);
                check(e.req, "oob_err", 32'(oob_err), 32'(e.err));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: output state straight out of reset
        check("R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
        check("R1", "oob_err after reset", 32'(oob_err), 32'h0);

        // R1: register reset values
        rd(12'h000, 32'h8002_0000, 1'b0, "R1");
        rd(12'h0A8, 32'h07B0_0000, 1'b0, "R1");
        rd(12'h0B0, 32'h8000_0000, 1'b0, "R1");

        // R5: direct status write, control unchanged
        wr(12'h0B0, 32'h0000_0000, 1'b0, "R5");
        rd(12'h0B0, 32'h0000_0000, 1'b0, "R5");
        rd(12'h0A8, 32'h07B0_0000, 1'b0, "R5");

        // R2 / R3: self-clearing start bits
        wr(12'h000, 32'hC000_1234, 1'b0, "R2");
        rd(12'h000, 32'h0000_1234, 1'b0, "R2");
        wr(12'h000, 32'h8000_00FF, 1'b0, "R2");
        rd(12'h000, 32'h0000_00FF, 1'b0, "R2");
        wr(12'h000, 32'h4FFF_FFFF, 1'b0, "R3");
        rd(12'h000, 32'h0FFF_FFFF, 1'b0, "R3");
        wr(12'h000, 32'h3FFF_0000, 1'b0, "R3");
        rd(12'h000, 32'h3FFF_0000, 1'b0, "R3");

        // R4: calibration start sets done, other status bits kept
        wr(12'h0A8, 32'h1234_5678, 1'b0, "R4");
        rd(12'h0A8, 32'h1234_5678, 1'b0, "R4");
        rd(12'h0B0, 32'h8000_0000, 1'b0, "R4");
        wr(12'h0B0, 32'h0000_5A5A, 1'b0, "R4");
        wr(12'h0A8, 32'h0000_0000, 1'b0, "R4");
        rd(12'h0B0, 32'h8000_5A5A, 1'b0, "R4");
        rd(12'h0A8, 32'h0000_0000, 1'b0, "R4");

        // R6: unimplemented offsets
        wr(12'h004, 32'hDEAD_BEEF, 1'b0, "R6");
        rd(12'h004, 32'h0000_0000, 1'b0, "R6");
        rd(12'h0AC, 32'h0000_0000, 1'b0, "R6");
        rd(12'h2E0, 32'h0000_0000, 1'b0, "R6");
        rd(12'h000, 32'h3FFF_0000, 1'b0, "R6");

        // R7: out-of-range accesses, back-to-back pulses, then quiet
        rd(12'h2E4, 32'h0000_0000, 1'b1, "R7");
        wr(12'hFFC, 32'hFFFF_FFFF, 1'b1, "R7");
        wr(12'h2E4, 32'h1111_1111, 1'b1, "R7");
        idle("R7");
        rd(12'h000, 32'h3FFF_0000, 1'b0, "R7");
        rd(12'h0B0, 32'h8000_5A5A, 1'b0, "R7");

        // R9: misaligned accesses are ignored with no error
        wr(12'h0B0, 32'h0000_0000, 1'b0, "R9");
        wr(12'h0AA, 32'hAAAA_AAAA, 1'b0, "R9");
        wr(12'h001, 32'hFFFF_FFFF, 1'b0, "R9");
        rd(12'h0B1, 32'h0000_0000, 1'b0, "R9");
        rd(12'h2E5, 32'h0000_0000, 1'b0, "R9");
        rd(12'h0B0, 32'h0000_0000, 1'b0, "R9");
        rd(12'h0A8, 32'h0000_0000, 1'b0, "R9");
        rd(12'h000, 32'h3FFF_0000, 1'b0, "R9");

        // R8: response timing around idle and write cycles
        idle("R8");
        rd(12'h0A8, 32'h0000_0000, 1'b0, "R8");
        rd(12'h000, 32'h3FFF_0000, 1'b0, "R8");
        wr(12'h0A8, 32'h0BAD_F00D, 1'b0, "R8");
        idle("R8");
        rd(12'h0A8, 32'h0BAD_F00D, 1'b0, "R8");
        idle("R8");

        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        summary();
        $finish;
    end

endmodule